// File: doc/BRIEF.md
# Quad-Pumped Bus Receive Capture

This block is the receive side of a 64-bit data bus that moves four transfers in every bus clock period. The bus lanes are split into four 16-bit groups. Each group has its own pair of source-synchronous strobes and its own polarity flag. For each group, the block takes successive transfers on alternating strobes. It restores the true value of each transfer from the active-low pins and that group's polarity flag. It then writes each transfer into its slot of a 256-bit line.

Each group counts its own beats. A skewed group can therefore finish later than its neighbours without corrupting the line. When all four groups have delivered four beats, the complete line passes to the bus clock domain. It appears there with a valid pulse one bus cycle long.

The strobes are modelled as capture enables sampled by a fast clock running at four times the bus clock. The two clocks come from one source, and their rising edges are aligned.

Top module: `qp_rx_capture`

## Requirements
- R1: After reset, `valid_o` is 0 and `line_o` is all zeros.
- R2: When a group's flag pin `dinv_n` is high (flag inactive), every captured bit of that group is the inverse of its pin level.
- R3: When a group's flag pin `dinv_n` is low (flag active), the captured bits equal the pin levels. The flag is sampled together with the data of that group on each beat.
- R4: The beats of a group are taken in this order: beats 0 and 2 on `stb_p[g]`, beats 1 and 3 on `stb_n[g]`. Beat n of group g lands at line bits [64n+16g+15 : 64n+16g].
- R5: A strobe of the kind that the group is not waiting for captures nothing and does not advance that group.
- R6: Groups advance independently. A line completes only when every group has captured four beats, whatever the relative timing of the groups.
- R7: While `drdy_n` is high, no beat is captured. Raising `drdy_n` discards all partially captured beats, and the next line starts again at beat 0.
- R8: On the first rising `clk_b` edge after the completing beat, `line_o` takes the new line and `valid_o` is high for exactly one bus cycle. At all other times `line_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_f | input | 1 | Fast capture clock, four times the bus clock, edge-aligned with it |
| clk_b | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset, applied in both domains |
| drdy_n | input | 1 | Active-low data-ready from the driver |
| d_n | input | 64 | Active-low data pins, four 16-bit groups |
| dinv_n | input | 4 | Active-low polarity flag, one per group |
| stb_p | input | 4 | Positive-strobe falling-edge events, one per group, as fast-clock enables |
| stb_n | input | 4 | Negative-strobe falling-edge events, one per group, as fast-clock enables |
| line_o | output | 256 | Assembled line, beat n at bits [64n+63:64n] |
| valid_o | output | 1 | One-bus-cycle pulse when a new line is presented |

## Verification
The hardest condition to reach from the ports is a line whose groups finish at different times. In that case the completion depends on the slowest group, while the others sit idle with their beats held. The bench creates this case by running four full beats on three groups only. It confirms that no pulse appears, then feeds the fourth group its beats alone and checks that the merged line is correct. A second harder case is a partial line cut off by data-ready. The bench captures two beats, raises `drdy_n` for one cycle, then sends a fresh line, and checks that nothing from the discarded beats reaches the output.

// File: rtl/qp_rx_capture.sv
module qp_rx_capture #(
  parameter int GROUPS = 4,
  parameter int LANE   = 16,
  parameter int BEATS  = 4
) (
  input  logic                            clk_f,
  input  logic                            clk_b,
  input  logic                            rst_n,
  input  logic                            drdy_n,
  input  logic [GROUPS*LANE-1:0]          d_n,
  input  logic [GROUPS-1:0]               dinv_n,
  input  logic [GROUPS-1:0]               stb_p,
  input  logic [GROUPS-1:0]               stb_n,
  output logic [GROUPS*LANE*BEATS-1:0]    line_o,
  output logic                            valid_o
);
  localparam int W    = GROUPS * LANE;
  localparam int LINE = W * BEATS;
  localparam int CW   = $clog2(BEATS);

  logic [CW-1:0]     cnt  [GROUPS];
  logic [LANE-1:0]   lane [GROUPS];
  logic [GROUPS-1:0] cap, done_q, done_nx;
  logic [LINE-1:0]   acc_q, acc_nx, hold_q;
  logic              tog_f, seen_b;
  logic              all_done;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign lane[g]    = d_n[g*LANE +: LANE] ^ {LANE{dinv_n[g]}};
    assign cap[g]     = !drdy_n && !done_q[g] && (cnt[g][0] ? stb_n[g] : stb_p[g]);
    assign done_nx[g] = done_q[g] | (cap[g] && cnt[g] == CW'(BEATS-1));

    always_ff @(posedge clk_f) begin
      if (!rst_n || drdy_n) cnt[g] <= '0;
      else if (cap[g])      cnt[g] <= cnt[g] + 1'b1;
    end

    a_r7_drdy_clear: assert property (@(posedge clk_f) disable iff (!rst_n)
      drdy_n |=> (cnt[g] == '0 && !done_q[g]));
    a_r5_no_advance: assert property (@(posedge clk_f) disable iff (!rst_n)
      (!drdy_n && !(cnt[g][0] ? stb_n[g] : stb_p[g])) |=> cnt[g] == $past(cnt[g]));
    a_r6_done_wrapped: assert property (@(posedge clk_f) disable iff (!rst_n)
      done_q[g] |-> cnt[g] == '0);
  end

  always_comb begin
    acc_nx = acc_q;
    for (int g = 0; g < GROUPS; g++)
      for (int b = 0; b < BEATS; b++)
        if (cap[g] && cnt[g] == CW'(b))
          acc_nx[b*W + g*LANE +: LANE] = lane[g];
  end

  assign all_done = &done_nx;

  always_ff @(posedge clk_f) begin
    if (!rst_n) begin
      done_q <= '0;
      acc_q  <= '0;
      hold_q <= '0;
      tog_f  <= 1'b0;
    end else if (drdy_n) begin
      done_q <= '0;
      acc_q  <= '0;
    end else if (all_done) begin
      hold_q <= acc_nx;
      tog_f  <= ~tog_f;
      done_q <= '0;
      acc_q  <= '0;
    end else begin
      done_q <= done_nx;
      acc_q  <= acc_nx;
    end
  end

  always_ff @(posedge clk_b) begin
    if (!rst_n) begin
      seen_b  <= 1'b0;
      valid_o <= 1'b0;
      line_o  <= '0;
    end else begin
      seen_b  <= tog_f;
      valid_o <= tog_f ^ seen_b;
      if (tog_f ^ seen_b) line_o <= hold_q;
    end
  end

  a_r8_line_hold: assert property (@(posedge clk_b) disable iff (!rst_n)
    !valid_o |-> $stable(line_o));
endmodule

// File: tb/qp_rx_capture_tb.sv
`timescale 1ns/1ps
module qp_rx_capture_tb;
  logic clk_f = 1'b0, clk_b = 1'b0, rst_n = 1'b0, drdy_n = 1'b1;
  logic [63:0]  d_n = '1;
  logic [3:0]   dinv_n = '1, stb_p = '0, stb_n = '0;
  logic [255:0] line_o;
  logic         valid_o;
  int n_run = 0, n_fail = 0;

  always #1 clk_f = ~clk_f;
  always #4 clk_b = ~clk_b;

  qp_rx_capture u_dut (.clk_f(clk_f), .clk_b(clk_b), .rst_n(rst_n), .drdy_n(drdy_n),
    .d_n(d_n), .dinv_n(dinv_n), .stb_p(stb_p), .stb_n(stb_n),
    .line_o(line_o), .valid_o(valid_o));

  localparam logic [255:0] V_LINE [4] = '{
    {64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210, 64'hDEAD_BEEF_CAFE_F00D, 64'h1111_2222_3333_4444},
    {64'hFFFF_0000_FFFF_0000, 64'h0000_FFFF_0000_FFFF, 64'hA5A5_5A5A_A5A5_5A5A, 64'h8000_0000_0000_0001},
    {64'h1357_9BDF_2468_ACE0, 64'h0F0F_F0F0_3C3C_C3C3, 64'h7777_8888_9999_AAAA, 64'hBBBB_CCCC_DDDD_EEEE},
    {64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0001_0002_0004_0008, 64'h4000_2000_1000_0800}};
  localparam logic [15:0] V_INV [4] = '{16'h0000, 16'hFFFF, 16'hA5C3, 16'h1248};

  task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_beat(input logic [63:0] v, input logic [3:0] inv,
                           input logic [3:0] pm, input logic [3:0] nm);
    @(negedge clk_f);
    for (int g = 0; g < 4; g++)
      d_n[g*16 +: 16] = inv[g] ? v[g*16 +: 16] : ~v[g*16 +: 16];
    dinv_n = ~inv;
    stb_p = pm;
    stb_n = nm;
  endtask

  task automatic idle();
    @(negedge clk_f);
    stb_p = '0;
    stb_n = '0;
  endtask

  task automatic send_line(input logic [255:0] ln, input logic [15:0] inv, input logic [3:0] mask);
    for (int b = 0; b < 4; b++)
      send_beat(ln[b*64 +: 64], inv[b*4 +: 4], (b % 2 == 0) ? mask : 4'h0, (b % 2 == 1) ? mask : 4'h0);
    idle();
  endtask

  task automatic expect_line(input logic [255:0] exp, input string tag);
    int pulses = 0;
    logic [255:0] got = '0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_b);
      if (valid_o) begin pulses++; got = line_o; end
    end
    check(pulses == 1, {tag, " pulse count"}, 256'(pulses), 256'd1);
    check(got == exp, {tag, " line"}, got, exp);
    check(line_o == exp && !valid_o, {tag, " hold after pulse (R8)"}, line_o, exp);
  endtask

  task automatic expect_none(input string tag);
    int pulses = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_b);
      if (valid_o) pulses++;
    end
    check(pulses == 0, tag, 256'(pulses), 256'd0);
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_b);
    check(valid_o == 1'b0, "R1 valid after reset", 256'(valid_o), 256'd0);
    check(line_o == '0, "R1 line after reset", line_o, '0);
    rst_n = 1'b1;
    drdy_n = 1'b0;
    @(negedge clk_b);

    // R2 R3 R4 R8: table of lines and per-beat polarity patterns
    for (int i = 0; i < 4; i++) begin
      @(posedge clk_b);
      send_line(V_LINE[i], V_INV[i], 4'hF);
      expect_line(V_LINE[i], $sformatf("R2/R3/R4/R8 vector %0d", i));
    end

    // R5: negative strobe while waiting for beat 0 is ignored
    send_beat(64'hBAD0_BAD0_BAD0_BAD0, 4'h0, 4'h0, 4'hF);
    idle();
    send_line(V_LINE[2], V_INV[1], 4'hF);
    expect_line(V_LINE[2], "R5 wrong strobe ignored");

    // R7: partial line dropped by data-ready
    send_beat(64'h5555_5555_5555_5555, 4'h0, 4'hF, 4'h0);
    send_beat(64'h6666_6666_6666_6666, 4'h0, 4'h0, 4'hF);
    idle();
    drdy_n = 1'b1;
    @(negedge clk_f);
    drdy_n = 1'b0;
    send_line(V_LINE[3], V_INV[2], 4'hF);
    expect_line(V_LINE[3], "R7 restart after abort");

    // R7: strobes with data-ready inactive capture nothing
    drdy_n = 1'b1;
    send_line(V_LINE[0], V_INV[0], 4'hF);
    expect_none("R7 no capture while not ready");
    drdy_n = 1'b0;
    @(negedge clk_f);

    // R6: three groups finish, the fourth lags
    send_line(V_LINE[1], V_INV[3], 4'h7);
    expect_none("R6 no line until every group done");
    send_line(V_LINE[1], V_INV[3], 4'h8);
    expect_line(V_LINE[1], "R6 late group merged");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule